// File: doc/BRIEF.md
# Packet Buffer Byte Port

This block gives a host a byte-wide window into a packet page memory. The memory holds a parameterised number of pages (four by default), each 2048 bytes deep. A 16-bit pointer register decides which page the window looks at, at which byte offset, and whether that offset steps forward after each data access. Two page numbers come in from the surrounding queue logic: the page at the head of the receive queue and the page the host has picked as the current packet. The pointer chooses between them.

The host reaches the block through a small register window. Addresses 0 and 1 hold the low and high bytes of the pointer. Addresses 2 and 3 are reserved. Addresses 4 to 7 are data lanes 0 to 3. A data access either uses a fixed offset plus the lane number, or uses one shared pointer that steps forward by one per access. A 32-bit data access is broken into four lane accesses in ascending lane order. The block is busy for the three cycles after a 32-bit data access is accepted.

Top module: `pktbuf_port`

## Requirements
- R1: After synchronous reset the pointer is zero, and both pointer bytes read back as 0x00.
- R2: A byte write to address 0 replaces only pointer bits 7:0, and a byte write to address 1 replaces only bits 15:8. A 32-bit write to address 0 loads all 16 bits from write data bits 15:0.
- R3: Reads of the pointer's high byte return bit 11 as zero (mask 0xF7 on the byte). A 32-bit pointer read returns the pointer ANDed with 0xF7FF in bits 15:0, with zeros above.
- R4: With pointer bit 15 set, data accesses go to the page given by the receive-head input. With bit 15 clear, they go to the page given by the packet-page input.
- R5: With pointer bit 14 clear, a data access on lane L (address 4+L) uses byte offset (pointer[10:0] + L) modulo 2048, and the pointer is left unchanged.
- R6: With pointer bit 14 set, a data access uses offset pointer[10:0] whatever the lane. After the access, bits 10:0 increase by one modulo 2048 and bits 15:11 stay the same.
- R7: A 32-bit data access (word flag set, address 4 to 7) performs lane 0, 1, 2, 3 accesses on consecutive cycles. Write data bits 8L+7:8L go to lane L, and a read returns lane L's byte in bits 8L+7:8L. With auto-increment on, the pointer advances four times.
- R8: Byte and pointer reads return valid data one cycle after acceptance. A 32-bit data read returns valid data four cycles after acceptance. Busy is high for exactly the three cycles after a 32-bit data access is accepted, and host requests made while busy is high are ignored.
- R9: Reserved addresses 2 and 3 read as zero, and writes to them change neither the pointer nor the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_en | input | 1 | Host request strobe |
| hst_we | input | 1 | 1 = write, 0 = read |
| hst_word | input | 1 | 1 = 32-bit access, 0 = byte access |
| hst_addr | input | 3 | 0/1 pointer low/high, 2/3 reserved, 4..7 data lanes 0..3 |
| hst_wdata | input | 32 | Write data; byte accesses use bits 7:0 |
| rx_head_page | input | PG_W | Page at the head of the receive queue |
| pkt_page | input | PG_W | Page selected as the current packet |
| hst_rdata | output | 32 | Read data, valid when hst_rvalid is high |
| hst_rvalid | output | 1 | Read data valid |
| hst_busy | output | 1 | Lane sequencer running; requests are ignored |

## Verification
The bench goes after the offset wrap at the top of the 2048-byte page, both in lane-offset mode and in auto-increment mode. A design that carried into bit 11 would land in the wrong page or corrupt the preserved upper pointer bits, and the bench would then read stale bytes or a wrong high byte. It mixes the two page sources with the same offset, so a swapped page select returns the other page's byte. It checks that a byte write to one half of the pointer leaves the other half intact and that bit 11 is hidden on readback. It checks lane order and byte placement in 32-bit accesses, where a reversed sequencer returns byte-swapped words. A request injected while busy is high must leave the pointer untouched.

// File: rtl/pbp_pkg.sv
package pbp_pkg;
  localparam int LANE_W = 2;

  typedef struct packed {
    logic              valid;
    logic              we;
    logic [LANE_W-1:0] lane;
    logic [7:0]        wbyte;
    logic              word;
  } lane_op_t;
endpackage

// File: rtl/pbp_ptr_reg.sv
module pbp_ptr_reg #(
  parameter int PTR_W = 16,
  parameter int OFS_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [7:0]       wd_lo,
  input  logic [7:0]       wd_hi,
  input  logic             adv,
  output logic [PTR_W-1:0] ptr
);
  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) ptr_q[7:0]       <= wd_lo;
      if (wr_hi) ptr_q[PTR_W-1:8] <= wd_hi;
    end else if (adv) begin
      ptr_q[OFS_W-1:0] <= ptr_q[OFS_W-1:0] + 1'b1;
    end
  end

  assign ptr = ptr_q;

  a_r1_reset_clear: assert property (@(posedge clk) rst |=> ptr_q == '0);

  a_r2_lo_keeps_hi: assert property (@(posedge clk) disable iff (rst)
    (wr_lo && !wr_hi) |=> ptr_q[PTR_W-1:8] == $past(ptr_q[PTR_W-1:8]));

  a_r2_hi_keeps_lo: assert property (@(posedge clk) disable iff (rst)
    (wr_hi && !wr_lo) |=> ptr_q[7:0] == $past(ptr_q[7:0]));

  a_r6_step_wraps: assert property (@(posedge clk) disable iff (rst)
    (adv && !wr_lo && !wr_hi) |=>
      (ptr_q[OFS_W-1:0] == OFS_W'($past(ptr_q[OFS_W-1:0]) + 1'b1)) &&
      (ptr_q[PTR_W-1:OFS_W] == $past(ptr_q[PTR_W-1:OFS_W])));

  a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!adv && !wr_lo && !wr_hi) |=> $stable(ptr_q));
endmodule

// File: rtl/pbp_addr_gen.sv
module pbp_addr_gen #(
  parameter int PG_W  = 2,
  parameter int OFS_W = 11,
  localparam int AW   = PG_W + OFS_W
) (
  input  logic                      sel_rx,
  input  logic                      auto_inc,
  input  logic [OFS_W-1:0]          ofs,
  input  logic [pbp_pkg::LANE_W-1:0] lane,
  input  logic [PG_W-1:0]           rx_head,
  input  logic [PG_W-1:0]           pkt_pg,
  output logic [AW-1:0]             addr
);
  logic [PG_W-1:0]  page;
  logic [OFS_W-1:0] eff_ofs;

  always_comb begin
    page    = sel_rx ? rx_head : pkt_pg;
    eff_ofs = auto_inc ? ofs : ofs + OFS_W'(lane);
    addr    = {page, eff_ofs};
  end
endmodule

// File: rtl/pbp_page_ram.sv
module pbp_page_ram #(
  parameter int DW = 8,
  parameter int AW = 13,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [0:DEPTH-1];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      rdata_q <= mem[addr];
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/pbp_lane_seq.sv
module pbp_lane_seq (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic                       start_we,
  input  logic [23:0]                upper,
  output logic                       active,
  output logic                       we,
  output logic [pbp_pkg::LANE_W-1:0] lane,
  output logic [7:0]                 wbyte
);
  localparam logic [pbp_pkg::LANE_W-1:0] LAST = '1;

  logic                       act_q;
  logic                       we_q;
  logic [pbp_pkg::LANE_W-1:0] cnt_q;
  logic [23:0]                dat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      we_q  <= 1'b0;
      dat_q <= '0;
    end else if (start) begin
      act_q <= 1'b1;
      cnt_q <= 2'd1;
      we_q  <= start_we;
      dat_q <= upper;
    end else if (act_q) begin
      dat_q <= dat_q >> 8;
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) act_q <= 1'b0;
    end
  end

  assign active = act_q;
  assign we     = we_q;
  assign lane   = cnt_q;
  assign wbyte  = dat_q[7:0];

  a_r7_lane_ascends: assert property (@(posedge clk) disable iff (rst)
    (act_q && cnt_q != LAST) |=> act_q && (cnt_q == $past(cnt_q) + 1'b1));

  a_r8_busy_ends: assert property (@(posedge clk) disable iff (rst)
    (act_q && cnt_q == LAST && !start) |=> !act_q);

  a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
    start |-> !act_q);
endmodule

// File: rtl/pktbuf_port.sv
module pktbuf_port #(
  parameter int PAGES = 4,
  parameter int OFS_W = 11,
  localparam int PG_W  = (PAGES > 1) ? $clog2(PAGES) : 1,
  localparam int AW    = PG_W + OFS_W,
  localparam int PTR_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hst_en,
  input  logic            hst_we,
  input  logic            hst_word,
  input  logic [2:0]      hst_addr,
  input  logic [31:0]     hst_wdata,
  input  logic [PG_W-1:0] rx_head_page,
  input  logic [PG_W-1:0] pkt_page,
  output logic [31:0]     hst_rdata,
  output logic            hst_rvalid,
  output logic            hst_busy
);
  import pbp_pkg::*;

  localparam int SEL_BIT  = PTR_W - 1;
  localparam int INC_BIT  = PTR_W - 2;
  localparam int HIDE_BIT = 11;
  localparam logic [PTR_W-1:0] RD_MASK = ~(PTR_W'(1) << HIDE_BIT);

  logic             accept, is_data, is_ptr, is_rsv;
  logic             seq_active, seq_we;
  logic [LANE_W-1:0] seq_lane;
  logic [7:0]       seq_byte;
  logic [PTR_W-1:0] ptr;
  logic             wr_lo, wr_hi, adv;
  logic [7:0]       wd_hi;
  lane_op_t         op;
  logic [AW-1:0]    ram_addr;
  logic [7:0]       ram_q;
  logic [PTR_W-1:0] ptr_rd;

  logic             rd_reg_q, rd_lane_q, rd_word_q;
  logic [LANE_W-1:0] rd_idx_q;
  logic [31:0]      reg_val_q;
  logic [23:0]      acc_q;

  assign accept  = hst_en && !seq_active;
  assign is_data = hst_addr[2];
  assign is_ptr  = (hst_addr[2:1] == 2'b00);
  assign is_rsv  = (hst_addr[2:1] == 2'b01);

  // Pointer write decode: a word write loads both bytes at once.
  assign wr_lo = accept && hst_we && is_ptr && (hst_word || !hst_addr[0]);
  assign wr_hi = accept && hst_we && is_ptr && (hst_word || hst_addr[0]);
  assign wd_hi = hst_word ? hst_wdata[15:8] : hst_wdata[7:0];

  pbp_lane_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (accept && is_data && hst_word),
    .start_we (hst_we),
    .upper    (hst_wdata[31:8]),
    .active   (seq_active),
    .we       (seq_we),
    .lane     (seq_lane),
    .wbyte    (seq_byte)
  );

  // Lane operation: sequencer first, host byte/word-start second.
  always_comb begin
    op = '0;
    if (seq_active) begin
      op.valid = 1'b1;
      op.we    = seq_we;
      op.lane  = seq_lane;
      op.wbyte = seq_byte;
      op.word  = 1'b1;
    end else if (accept && is_data) begin
      op.valid = 1'b1;
      op.we    = hst_we;
      op.lane  = hst_word ? '0 : hst_addr[1:0];
      op.wbyte = hst_wdata[7:0];
      op.word  = hst_word;
    end
  end

  assign adv = op.valid && ptr[INC_BIT];

  pbp_ptr_reg #(.PTR_W(PTR_W), .OFS_W(OFS_W)) u_ptr (
    .clk   (clk),
    .rst   (rst),
    .wr_lo (wr_lo),
    .wr_hi (wr_hi),
    .wd_lo (hst_wdata[7:0]),
    .wd_hi (wd_hi),
    .adv   (adv),
    .ptr   (ptr)
  );

  pbp_addr_gen #(.PG_W(PG_W), .OFS_W(OFS_W)) u_addr (
    .sel_rx   (ptr[SEL_BIT]),
    .auto_inc (ptr[INC_BIT]),
    .ofs      (ptr[OFS_W-1:0]),
    .lane     (op.lane),
    .rx_head  (rx_head_page),
    .pkt_pg   (pkt_page),
    .addr     (ram_addr)
  );

  pbp_page_ram #(.DW(8), .AW(AW)) u_ram (
    .clk   (clk),
    .en    (op.valid),
    .we    (op.we),
    .addr  (ram_addr),
    .wdata (op.wbyte),
    .rdata (ram_q)
  );

  assign ptr_rd = ptr & RD_MASK;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_reg_q  <= 1'b0;
      rd_lane_q <= 1'b0;
      rd_word_q <= 1'b0;
      rd_idx_q  <= '0;
      reg_val_q <= '0;
      acc_q     <= '0;
    end else begin
      rd_reg_q  <= accept && !hst_we && !is_data;
      rd_lane_q <= op.valid && !op.we;
      rd_word_q <= op.word;
      rd_idx_q  <= op.lane;
      if (is_ptr) begin
        if (hst_word)         reg_val_q <= {16'h0000, ptr_rd};
        else if (hst_addr[0]) reg_val_q <= {24'h000000, ptr_rd[PTR_W-1:8]};
        else                  reg_val_q <= {24'h000000, ptr_rd[7:0]};
      end else begin
        reg_val_q <= '0;
      end
      if (rd_lane_q && rd_word_q && rd_idx_q != '1)
        acc_q[{rd_idx_q, 3'b000} +: 8] <= ram_q;
    end
  end

  assign hst_rvalid = rd_reg_q || (rd_lane_q && (!rd_word_q || rd_idx_q == '1));
  assign hst_rdata  = rd_reg_q  ? reg_val_q :
                      rd_word_q ? {ram_q, acc_q} : {24'h000000, ram_q};
  assign hst_busy   = seq_active;

  a_r4_page_source: assert property (@(posedge clk) disable iff (rst)
    (op.valid && ptr[SEL_BIT]) |-> ram_addr[AW-1:OFS_W] == rx_head_page);

  a_r4_page_packet: assert property (@(posedge clk) disable iff (rst)
    (op.valid && !ptr[SEL_BIT]) |-> ram_addr[AW-1:OFS_W] == pkt_page);

  a_r8_byte_latency: assert property (@(posedge clk) disable iff (rst)
    (accept && !hst_we && !(is_data && hst_word)) |=> hst_rvalid);

  a_r9_rsv_no_effect: assert property (@(posedge clk) disable iff (rst)
    (accept && is_rsv) |=> $stable(ptr));

  a_r3_hidden_bit: assert property (@(posedge clk) disable iff (rst)
    rd_reg_q |-> !reg_val_q[HIDE_BIT] && (reg_val_q[31:16] == 16'h0000));
endmodule

// File: tb/pktbuf_port_tb.sv
module pktbuf_port_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hst_en = 1'b0, hst_we = 1'b0, hst_word = 1'b0;
  logic [2:0]  hst_addr = '0;
  logic [31:0] hst_wdata = '0;
  logic [1:0]  rx_head_page = '0, pkt_page = '0;
  logic [31:0] hst_rdata;
  logic        hst_rvalid, hst_busy;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] mp = '0;
  logic [7:0]  mem_m [0:8191];

  always #2.5 clk = ~clk;

  pktbuf_port dut_i (
    .clk(clk), .rst(rst), .hst_en(hst_en), .hst_we(hst_we), .hst_word(hst_word),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata), .rx_head_page(rx_head_page),
    .pkt_page(pkt_page), .hst_rdata(hst_rdata), .hst_rvalid(hst_rvalid),
    .hst_busy(hst_busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference address for one lane access; advances the model pointer (R5, R6).
  function automatic logic [12:0] m_lane(input logic [1:0] lane);
    logic [10:0] o;
    logic [1:0]  pg;
    pg = mp[15] ? rx_head_page : pkt_page;
    o  = mp[14] ? mp[10:0] : mp[10:0] + {9'd0, lane};
    if (mp[14]) mp[10:0] = mp[10:0] + 11'd1;
    return {pg, o};
  endfunction

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && hst_rvalid) begin
      if (exp_q.size() == 0) chk("R8 unexpected rvalid", hst_rdata, 32'hxxxxxxxx);
      else chk(tag_q.pop_front(), hst_rdata, exp_q.pop_front());
    end
  end

  task automatic issue(input logic we, input logic word, input logic [2:0] a,
                       input logic [31:0] d);
    @(negedge clk);
    hst_en = 1'b1; hst_we = we; hst_word = word; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_en = 1'b0;
  endtask

  task automatic busy_window();
    chk("R8 busy c1", {31'd0, hst_busy}, 32'd1);
    @(negedge clk); chk("R8 busy c2", {31'd0, hst_busy}, 32'd1);
    @(negedge clk); chk("R8 busy c3", {31'd0, hst_busy}, 32'd1);
    @(negedge clk); chk("R8 busy end", {31'd0, hst_busy}, 32'd0);
  endtask

  task automatic wr_b(input logic [2:0] a, input logic [7:0] d);
    if (a[2]) mem_m[m_lane(a[1:0])] = d;
    else if (a[2:1] == 2'b00) begin
      if (a[0]) mp[15:8] = d; else mp[7:0] = d;
    end
    issue(1'b1, 1'b0, a, {24'd0, d});
  endtask

  task automatic rd_b(input logic [2:0] a, input string tag);
    logic [31:0] e;
    if (a[2]) e = {24'd0, mem_m[m_lane(a[1:0])]};
    else if (a[2:1] == 2'b00) e = a[0] ? {24'd0, mp[15:8] & 8'hF7} : {24'd0, mp[7:0]};
    else e = 32'd0;
    exp_q.push_back(e); tag_q.push_back(tag);
    issue(1'b0, 1'b0, a, 32'd0);
  endtask

  task automatic wr_w(input logic [2:0] a, input logic [31:0] d);
    if (a[2]) begin
      for (int l = 0; l < 4; l++) mem_m[m_lane(2'(l))] = d[8*l +: 8];
    end else if (a[2:1] == 2'b00) mp = d[15:0];
    issue(1'b1, 1'b1, a, d);
    if (a[2]) busy_window();
  endtask

  task automatic rd_w(input logic [2:0] a, input string tag);
    logic [31:0] e;
    e = '0;
    if (a[2]) begin
      for (int l = 0; l < 4; l++) e[8*l +: 8] = mem_m[m_lane(2'(l))];
    end else if (a[2:1] == 2'b00) e = {16'd0, mp & 16'hF7FF};
    exp_q.push_back(e); tag_q.push_back(tag);
    issue(1'b0, 1'b1, a, 32'd0);
    if (a[2]) busy_window();
  endtask

  task automatic set_ptr(input logic [15:0] v);
    wr_w(3'd0, {16'd0, v});
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    // R1: reset state
    rd_b(3'd0, "R1 ptr lo after reset");
    rd_b(3'd1, "R1 ptr hi after reset");
    chk("R1 not busy", {31'd0, hst_busy}, 32'd0);
    // R2 / R3: byte halves and hidden bit 11
    wr_b(3'd0, 8'h34);
    wr_b(3'd1, 8'h0F);
    rd_b(3'd0, "R2 lo kept after hi write");
    rd_b(3'd1, "R3 hi masks bit 11");
    wr_b(3'd0, 8'h56);
    rd_b(3'd1, "R2 hi kept after lo write");
    set_ptr(16'h4BCD);
    rd_w(3'd0, "R3 word ptr read masked");
    // R5: lane offsets, page from packet input
    rx_head_page = 2'd1; pkt_page = 2'd2;
    set_ptr(16'h0010);
    for (int l = 0; l < 4; l++) wr_b(3'(4 + l), 8'hA0 + 8'(l));
    rd_w(3'd0, "R5 ptr unchanged");
    rd_b(3'd6, "R5 lane 2 offset");
    rd_b(3'd7, "R5 lane 3 offset");
    set_ptr(16'h07FE);
    wr_b(3'd7, 8'h5A);
    set_ptr(16'h0001);
    rd_b(3'd4, "R5 lane offset wraps in page");
    // R6: auto-increment ignores lane, wraps, preserves upper bits
    set_ptr(16'h4100);
    for (int k = 0; k < 4; k++) wr_b(3'd5, 8'hC0 + 8'(k));
    rd_w(3'd0, "R6 ptr advanced by four");
    set_ptr(16'h0100);
    rd_w(3'd4, "R7 word read lane bytes");
    set_ptr(16'h57FF);
    wr_b(3'd4, 8'h77);
    rd_b(3'd1, "R6 upper bits kept on wrap");
    rd_b(3'd0, "R6 offset wrapped to zero");
    // R4: page select with same offset
    pkt_page = 2'd0;
    set_ptr(16'h0200);
    wr_b(3'd4, 8'h11);
    rx_head_page = 2'd3;
    set_ptr(16'hC200);
    wr_w(3'd4, 32'hDDCCBBAA);
    rd_w(3'd0, "R7 ptr advanced four by word");
    set_ptr(16'h0200);
    rd_b(3'd4, "R4 packet page 0 untouched");
    pkt_page = 2'd3;
    rd_w(3'd4, "R4 R7 word from rx page");
    set_ptr(16'h4201);
    rd_w(3'd4, "R7 autoinc word read");
    rd_w(3'd0, "R7 ptr after autoinc word");
    // R9: reserved addresses
    wr_b(3'd2, 8'hFF);
    wr_b(3'd3, 8'hFF);
    rd_b(3'd2, "R9 reserved reads zero");
    rd_b(3'd3, "R9 reserved 3 reads zero");
    rd_w(3'd0, "R9 ptr unchanged by reserved");
    // R8: request while busy is ignored
    set_ptr(16'h0300);
    for (int l = 0; l < 4; l++) mem_m[m_lane(2'(l))] = 8'h90 + 8'(l);
    issue(1'b1, 1'b1, 3'd4, 32'h93929190);
    hst_en = 1'b1; hst_we = 1'b1; hst_word = 1'b0; hst_addr = 3'd0; hst_wdata = 32'hFF;
    @(negedge clk); hst_en = 1'b0;
    repeat (3) @(negedge clk);
    rd_w(3'd0, "R8 ptr untouched while busy");
    rd_w(3'd4, "R8 busy word data intact");
    repeat (4) @(negedge clk);
    chk("R8 scoreboard drained", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R8 watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule